// File: doc/BRIEF.md
# Clock Configuration Guard

This block holds the configuration state of a clock system behind a write-lock layer. A CPU-style write bus (address, data, write strobe) reaches a protect register, a mode register with two set-only lock bits, three clock-control registers and two PLL configuration registers. The protect register decides whether the mode register and the clock registers accept writes at all. Reads are combinational: `rdata` shows the register selected by `addr`.

The two lock bits harden the configuration after boot. The system-clock lock freezes the CPU clock source, the oscillator stop and detect controls, the stop-mode entry bit, the wait-mode clock-stop bit and every PLL bit. It also keeps the CPU clock running through a wait request. The watchdog lock moves the watchdog onto the on-chip oscillator, keeps its clock enabled during wait, and blocks entry to stop mode. Only reset clears either lock. The block drives control levels only. The oscillators, the PLL and the watchdog counter sit outside it.

Top module: `clk_guard`

## Requirements
- R1: After reset every mapped register reads 0x00. After reset `wdt_src_osc`, `cnt_sel`, `stop_mode_en`, `main_osc_stop`, `cpu_src_sel` and `osc_det_en` are all 0.
- R2: The protect register sits at 0x0A. Its bit 1 enables writes to the mode register at 0x13, and its bit 0 enables writes to the clock registers at 0x06, 0x07, 0x0C, 0x1C and 0x1D. A write to a register whose enable bit is 0 leaves that register unchanged.
- R3: Mode register bit 1 is the system-clock lock and bit 2 is the watchdog lock. Writing 1 sets a lock bit. A later write of 0 leaves it at 1, and only reset clears it.
- R4: While the system-clock lock is 1, writes leave these bits unchanged: 0x06 bits 7, 5 and 2; 0x07 bits 7 and 0; 0x0C bit 0. The other bits of those registers still take written data.
- R5: While the system-clock lock is 1, writes leave all bits of 0x1C and 0x1D unchanged.
- R6: `cpu_clk_en` is 0 while `wait_req` is 1, unless the system-clock lock is 1. In that case it stays 1.
- R7: `wdt_src_osc` becomes 1 in the cycle after a write setting the watchdog lock is accepted. While the watchdog lock is 1, writing 1 to 0x07 bit 0 is discarded.
- R8: `wdt_clk_en` is 0 while `wait_req` is 1, unless the watchdog lock is 1. In that case it stays 1.
- R9: Mode register bits 7:6 hold the count-source code and drive `cnt_sel`. The codes are 00 (defer to another select), 01 (crystal) and 10 (on-chip oscillator). A write carrying 11 keeps the previous code and still applies the write's other bits.
- R10: Mode register bits 5:3 and 0 always read 0. Protect register bits 7:2 always read 0.
- R11: `rdata` shows the current contents of the register addressed by `addr` in the same cycle. Unmapped addresses read 0x00.
- R12: The register bits drive these outputs: `stop_mode_en` = 0x07 bit 0, `main_osc_stop` = 0x06 bit 5, `cpu_src_sel` = {0x07 bit 7, 0x06 bit 7}, `osc_det_en` = 0x0C bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| wait_req | input | 1 | Wait-mode request |
| wdt_src_osc | output | 1 | Watchdog counts the on-chip oscillator |
| cnt_sel | output | 2 | Count-source select code |
| stop_mode_en | output | 1 | Stop-mode entry request |
| cpu_clk_en | output | 1 | CPU clock enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| cpu_src_sel | output | 2 | CPU clock source select bits |
| main_osc_stop | output | 1 | Main oscillator stop |
| osc_det_en | output | 1 | Oscillation-stop detection enable |

## Verification
The following properties are checked on every cycle:
- Both lock bits are sticky.
- The frozen clock outputs and the PLL registers stay stable under the system-clock lock.
- Stop mode cannot rise under the watchdog lock.
- The count code never holds 11.
- The mode register's reserved bits read 0.
- The mode register is stable while its write enable is off.

Some behaviour is shown only by the bench scenarios. These are the exact mixing of frozen and free bits inside a partly locked register, the one-cycle delay of the watchdog source switch, and the clock-enable responses to a wait request with and without each lock.

// File: rtl/clk_guard_pkg.sv
package clk_guard_pkg;
  localparam int DATA_W = 8;
  localparam int NCTRL  = 5;

  typedef logic [DATA_W-1:0] word_t;

  localparam word_t PROT_ADDR = 8'h0A;
  localparam word_t MODE_ADDR = 8'h13;

  localparam int PROT_CLK_BIT  = 0;
  localparam int PROT_MODE_BIT = 1;
  localparam int MODE_SYS_BIT  = 1;
  localparam int MODE_WDT_BIT  = 2;
  localparam int CNT_LSB       = 6;
  localparam word_t MODE_RSVD  = 8'h39;

  // indices into the clock-control bank
  localparam int CR_A  = 0;
  localparam int CR_B  = 1;
  localparam int CR_C  = 2;
  localparam int PLL_A = 3;
  localparam int PLL_B = 4;

  localparam word_t CTRL_ADDR     [NCTRL] = '{8'h06, 8'h07, 8'h0C, 8'h1C, 8'h1D};
  localparam word_t CTRL_RST      [NCTRL] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
  localparam word_t CTRL_SYS_MASK [NCTRL] = '{8'hA4, 8'h81, 8'h01, 8'hFF, 8'hFF};
  localparam word_t CTRL_WDT_MASK [NCTRL] = '{8'h00, 8'h01, 8'h00, 8'h00, 8'h00};

  // bit positions inside the clock-control registers
  localparam int A_WAIT_STOP = 2;
  localparam int A_MAIN_STOP = 5;
  localparam int A_CPU_SRC   = 7;
  localparam int B_STOP      = 0;
  localparam int B_CPU_SRC   = 7;
  localparam int C_OSC_DET   = 0;
endpackage

// File: rtl/clk_guard_rst_sync.sv
module clk_guard_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shf_q;
  logic [STAGES-1:0] shf_d;

  always_comb begin
    shf_d = {shf_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shf_q <= '0;
    else        shf_q <= shf_d;
  end

  assign rst_sync_n = shf_q[STAGES-1];
endmodule

// File: rtl/clk_guard_prot_reg.sv
module clk_guard_prot_reg
  import clk_guard_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  word_t wdata,
  output logic  clk_we,
  output logic  mode_we
);
  logic [1:0] en_q;
  logic [1:0] en_d;

  always_comb begin
    en_d = {wdata[PROT_MODE_BIT], wdata[PROT_CLK_BIT]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= en_d;
  end

  assign clk_we  = en_q[0];
  assign mode_we = en_q[1];
endmodule

// File: rtl/clk_guard_mode_reg.sv
module clk_guard_mode_reg
  import clk_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  word_t      wdata,
  output logic       sys_lock,
  output logic       wdt_lock,
  output logic [1:0] cnt_code,
  output word_t      img
);
  logic       sys_q, sys_d;
  logic       wdt_q, wdt_d;
  logic [1:0] cnt_q, cnt_d;
  logic [1:0] cnt_wr;

  always_comb begin
    cnt_wr = wdata[CNT_LSB +: 2];
    sys_d  = sys_q | wdata[MODE_SYS_BIT];
    wdt_d  = wdt_q | wdata[MODE_WDT_BIT];
    cnt_d  = (cnt_wr == 2'b11) ? cnt_q : cnt_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q <= 1'b0;
      wdt_q <= 1'b0;
      cnt_q <= 2'b00;
    end else if (wr) begin
      sys_q <= sys_d;
      wdt_q <= wdt_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    img                = '0;
    img[MODE_SYS_BIT]  = sys_q;
    img[MODE_WDT_BIT]  = wdt_q;
    img[CNT_LSB +: 2]  = cnt_q;
  end

  assign sys_lock = sys_q;
  assign wdt_lock = wdt_q;
  assign cnt_code = cnt_q;
endmodule

// File: rtl/clk_guard_ctrl_reg.sv
module clk_guard_ctrl_reg
  import clk_guard_pkg::*;
#(
  parameter word_t RST_VAL  = '0,
  parameter word_t SYS_MASK = '0,
  parameter word_t WDT_MASK = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  word_t wdata,
  input  logic  sys_lock,
  input  logic  wdt_lock,
  output word_t q
);
  word_t q_r, q_d, hold;

  always_comb begin
    // frozen bits: every masked bit under the system lock,
    // and only attempted sets of masked bits under the watchdog lock
    hold = ({DATA_W{sys_lock}} & SYS_MASK)
         | ({DATA_W{wdt_lock}} & WDT_MASK & wdata);
    q_d  = (q_r & hold) | (wdata & ~hold);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= RST_VAL;
    else if (wr) q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/clk_guard.sv
module clk_guard
  import clk_guard_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              wait_req,
  output logic              wdt_src_osc,
  output logic [1:0]        cnt_sel,
  output logic              stop_mode_en,
  output logic              cpu_clk_en,
  output logic              wdt_clk_en,
  output logic [1:0]        cpu_src_sel,
  output logic              main_osc_stop,
  output logic              osc_det_en
);
  logic             rst_int_n;
  logic             prot_clk_we, prot_mode_we;
  logic             prot_wr, mode_wr;
  logic             sys_lock, wdt_lock;
  logic [1:0]       cnt_code;
  word_t            mode_img;
  logic [NCTRL-1:0] ctrl_wr;
  word_t            ctrl_q [NCTRL];
  word_t            pll_a_q, pll_b_q;

  clk_guard_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  always_comb begin
    prot_wr = wr_en && (addr == ADDR_W'(PROT_ADDR));
    mode_wr = wr_en && prot_mode_we && (addr == ADDR_W'(MODE_ADDR));
    for (int i = 0; i < NCTRL; i++) begin
      ctrl_wr[i] = wr_en && prot_clk_we && (addr == ADDR_W'(CTRL_ADDR[i]));
    end
  end

  clk_guard_prot_reg u_prot (
    .clk(clk), .rst_n(rst_int_n), .wr(prot_wr), .wdata(wdata),
    .clk_we(prot_clk_we), .mode_we(prot_mode_we)
  );

  clk_guard_mode_reg u_mode (
    .clk(clk), .rst_n(rst_int_n), .wr(mode_wr), .wdata(wdata),
    .sys_lock(sys_lock), .wdt_lock(wdt_lock), .cnt_code(cnt_code), .img(mode_img)
  );

  for (genvar g = 0; g < NCTRL; g++) begin : g_ctrl
    clk_guard_ctrl_reg #(
      .RST_VAL (CTRL_RST[g]),
      .SYS_MASK(CTRL_SYS_MASK[g]),
      .WDT_MASK(CTRL_WDT_MASK[g])
    ) u_reg (
      .clk(clk), .rst_n(rst_int_n), .wr(ctrl_wr[g]), .wdata(wdata),
      .sys_lock(sys_lock), .wdt_lock(wdt_lock), .q(ctrl_q[g])
    );
  end

  assign pll_a_q = ctrl_q[PLL_A];
  assign pll_b_q = ctrl_q[PLL_B];

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(PROT_ADDR)) begin
      rdata[PROT_CLK_BIT]  = prot_clk_we;
      rdata[PROT_MODE_BIT] = prot_mode_we;
    end
    if (addr == ADDR_W'(MODE_ADDR)) rdata = mode_img;
    for (int i = 0; i < NCTRL; i++) begin
      if (addr == ADDR_W'(CTRL_ADDR[i])) rdata = ctrl_q[i];
    end
  end

  assign wdt_src_osc   = wdt_lock;
  assign cnt_sel       = cnt_code;
  assign stop_mode_en  = ctrl_q[CR_B][B_STOP];
  assign main_osc_stop = ctrl_q[CR_A][A_MAIN_STOP];
  assign cpu_src_sel   = {ctrl_q[CR_B][B_CPU_SRC], ctrl_q[CR_A][A_CPU_SRC]};
  assign osc_det_en    = ctrl_q[CR_C][C_OSC_DET];
  assign cpu_clk_en    = !wait_req || sys_lock;
  assign wdt_clk_en    = !wait_req || wdt_lock;
endmodule

// File: rtl/clk_guard_chk.sv
module clk_guard_chk
  import clk_guard_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rdata,
  input logic              prot_mode_we,
  input logic              sys_lock,
  input logic              wdt_lock,
  input logic [1:0]        cnt_sel,
  input logic              stop_mode_en,
  input logic              main_osc_stop,
  input logic [1:0]        cpu_src_sel,
  input logic              osc_det_en,
  input logic [7:0]        pll_a_q,
  input logic [7:0]        pll_b_q
);
  // R3
  sys_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_lock |=> sys_lock);

  // R3
  wdt_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_lock |=> wdt_lock);

  // R4
  sys_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_lock |=> ($stable(main_osc_stop) && $stable(cpu_src_sel)
                  && $stable(osc_det_en) && $stable(stop_mode_en)));

  // R5
  pll_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_lock |=> ($stable(pll_a_q) && $stable(pll_b_q)));

  // R7
  no_stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_lock && !stop_mode_en) |=> !stop_mode_en);

  // R2
  mode_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_mode_we |=> ($stable(cnt_sel) && $stable(sys_lock) && $stable(wdt_lock)));

  // R9
  no_rsvd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_sel != 2'b11);

  // R10
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(MODE_ADDR)) |-> ((rdata & MODE_RSVD) == 8'h00));
endmodule

bind clk_guard clk_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rdata(rdata),
  .prot_mode_we(prot_mode_we), .sys_lock(sys_lock), .wdt_lock(wdt_lock),
  .cnt_sel(cnt_sel), .stop_mode_en(stop_mode_en), .main_osc_stop(main_osc_stop),
  .cpu_src_sel(cpu_src_sel), .osc_det_en(osc_det_en),
  .pll_a_q(pll_a_q), .pll_b_q(pll_b_q)
);

// File: tb/clk_guard_tb.sv
`timescale 1ns/1ps
module clk_guard_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] addr, wdata, rdata;
  logic       wait_req;
  logic       wdt_src_osc, stop_mode_en, cpu_clk_en, wdt_clk_en;
  logic       main_osc_stop, osc_det_en;
  logic [1:0] cnt_sel, cpu_src_sel;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  clk_guard u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .wait_req(wait_req), .wdt_src_osc(wdt_src_osc),
    .cnt_sel(cnt_sel), .stop_mode_en(stop_mode_en), .cpu_clk_en(cpu_clk_en),
    .wdt_clk_en(wdt_clk_en), .cpu_src_sel(cpu_src_sel),
    .main_osc_stop(main_osc_stop), .osc_det_en(osc_det_en)
  );

  // {req, addr, wdata, expected readback}
  localparam int NV = 21;
  localparam logic [27:0] VEC [NV] = '{
    {4'd2,  8'h13, 8'h80, 8'h00},  // R2 mode locked out by protect
    {4'd2,  8'h06, 8'hFF, 8'h00},  // R2 clock regs locked out
    {4'd10, 8'h0A, 8'hFF, 8'h03},  // R10 protect upper bits read 0
    {4'd10, 8'h13, 8'hB9, 8'h80},  // R10 reserved bits dropped
    {4'd9,  8'h13, 8'hC0, 8'h80},  // R9 code 11 keeps old
    {4'd9,  8'h13, 8'h40, 8'h40},  // R9
    {4'd11, 8'h06, 8'hA5, 8'hA5},  // R11
    {4'd11, 8'h07, 8'h80, 8'h80},  // R11
    {4'd11, 8'h1C, 8'h3C, 8'h3C},  // R11
    {4'd11, 8'h1D, 8'h55, 8'h55},  // R11
    {4'd11, 8'h0C, 8'h01, 8'h01},  // R11
    {4'd3,  8'h13, 8'h42, 8'h42},  // R3 set system lock
    {4'd3,  8'h13, 8'h40, 8'h42},  // R3 zero write keeps lock
    {4'd4,  8'h06, 8'h5A, 8'hFE},  // R4 partial freeze
    {4'd4,  8'h07, 8'h01, 8'h80},  // R4
    {4'd4,  8'h07, 8'h7E, 8'hFE},  // R4
    {4'd4,  8'h0C, 8'hF0, 8'hF1},  // R4
    {4'd5,  8'h1C, 8'h00, 8'h3C},  // R5
    {4'd5,  8'h1D, 8'hAA, 8'h55},  // R5
    {4'd2,  8'h0A, 8'h00, 8'h00},  // R2
    {4'd2,  8'h13, 8'h00, 8'h42}   // R2 mode write ignored
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; wait_req = 1'b0;
    do_reset();

    // R1 reset state
    rd("R1", 8'h0A, 8'h00);
    rd("R1", 8'h13, 8'h00);
    rd("R1", 8'h06, 8'h00);
    rd("R1", 8'h1D, 8'h00);
    chk("R1", {3'b0, wdt_src_osc, stop_mode_en, main_osc_stop, osc_det_en, 1'b0}, 8'h00);
    chk("R1", {4'b0, cnt_sel, cpu_src_sel}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rd($sformatf("R%0d", VEC[i][27:24]), VEC[i][23:16], VEC[i][7:0]);
    end

    // R12 output mirrors after the table
    chk("R12", {6'b0, cpu_src_sel}, 8'h03);
    chk("R12", {6'b0, main_osc_stop, osc_det_en}, 8'h03);
    chk("R12", {7'b0, stop_mode_en}, 8'h00);
    chk("R9", {6'b0, cnt_sel}, 8'h01);
    rd("R11", 8'h55, 8'h00);
    // R6 system lock keeps CPU clock in wait
    wait_req = 1'b1; #1;
    chk("R6", {7'b0, cpu_clk_en}, 8'h01);
    chk("R8", {7'b0, wdt_clk_en}, 8'h00);
    wait_req = 1'b0;

    // second reset clears locks
    do_reset();
    rd("R1", 8'h13, 8'h00);
    wait_req = 1'b1; #1;
    chk("R6", {7'b0, cpu_clk_en}, 8'h00);
    chk("R8", {7'b0, wdt_clk_en}, 8'h00);
    wait_req = 1'b0;

    wr(8'h0A, 8'h03);
    wr(8'h07, 8'h01);
    chk("R12", {7'b0, stop_mode_en}, 8'h01);
    wr(8'h07, 8'h00);
    chk("R12", {7'b0, stop_mode_en}, 8'h00);

    // R7 watchdog lock timing
    @(negedge clk);
    addr = 8'h13; wdata = 8'h04; wr_en = 1'b1;
    #1;
    chk("R7", {7'b0, wdt_src_osc}, 8'h00);
    @(posedge clk); #1;
    chk("R7", {7'b0, wdt_src_osc}, 8'h01);
    @(negedge clk); wr_en = 1'b0;

    wr(8'h07, 8'h01);
    chk("R7", {7'b0, stop_mode_en}, 8'h00);
    rd("R7", 8'h07, 8'h00);
    wr(8'h07, 8'h80);
    rd("R7", 8'h07, 8'h80);
    wr(8'h13, 8'h00);
    rd("R3", 8'h13, 8'h04);

    wait_req = 1'b1; #1;
    chk("R8", {7'b0, wdt_clk_en}, 8'h01);
    chk("R6", {7'b0, cpu_clk_en}, 8'h00);
    wr(8'h13, 8'h02);
    #1;
    chk("R6", {7'b0, cpu_clk_en}, 8'h01);
    wait_req = 1'b0;
    rd("R3", 8'h13, 8'h06);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule